// File: doc/BRIEF.md
# Single-Cycle Misaligned Operand Port

This unit sits between a load/store pipeline and a memory built from four independent byte-wide banks. It accepts a 1-, 2- or 4-byte operand at any byte address and finishes the access in one request. There is no alignment fault and no split into two memory transactions, even when the operand runs across a word boundary.

The low two address bits name the bank that holds operand byte 0. Any bank numbered below that starting bank belongs to the next word, so it receives the word address plus one. Every other bank receives the word address unchanged. A byte crossbar carries operand lanes to banks on a write and carries bank bytes back to operand lanes on a read. The operand is little-endian. Bank write enables cover only the bytes of the operand. The assembled read value is registered and appears one cycle after the request.

The banks are expected to return read data combinationally in the cycle of the request, and to commit writes at the clock edge that ends it.

Top module: `unaligned_bank_port`

## Requirements
- R1: While reset is held and right after it is released, `rdValid` is 0 and `rdData` is 0.
- R2: For a request at byte address A, bank b (0 to 3) is driven with word address A[31:2]+1 when b < A[1:0], and with A[31:2] otherwise. The increment wraps modulo 2^30.
- R3: On a write, bank (A[1:0]+i) mod 4 is driven with operand byte i, taken from `reqWdata` bits 8i+7..8i, for every byte i of the operand.
- R4: The size code sets the operand length: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. During a valid write, `bankWe` bit b is 1 exactly when b = (A[1:0]+i) mod 4 for some operand byte i.
- R5: On a read, byte i of `rdData` (bits 8i+7..8i) equals the byte returned by bank (A[1:0]+i) mod 4 for every operand byte i. All bytes beyond the operand length are 0.
- R6: `rdValid` is 1 in the cycle after a valid read request and 0 after any other cycle. `rdData` holds its value across cycles that carry no read.
- R7: An operand that spans a word boundary, including the wrap from the top of the address space to 0, is written and read back correctly with a single request each.
- R8: A read request or an idle cycle drives no bank write enable, so the memory contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Byte address of the operand |
| reqSize | input | 2 | Operand length code (0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes) |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqWdata | input | 32 | Write operand, little-endian lanes |
| bankRdata | input | 32 | Read byte of bank b on bits 8b+7..8b |
| bankAddr | output | 120 | Word address of bank b on bits 30b+29..30b |
| bankWdata | output | 32 | Write byte of bank b on bits 8b+7..8b |
| bankWe | output | 4 | Write enable per bank |
| rdData | output | 32 | Registered read operand |
| rdValid | output | 1 | `rdData` was loaded by the previous cycle's read |

## Verification
Every combination of the 64 byte addresses of a small model memory and the three operand lengths is written and then read back twice: once at the same length and once as a full word. This covers all four starting banks and every word-boundary crossing. It also shows whether neighbouring bytes were spared by the enables. Reads at addresses just below the top of the address space check that the per-bank increment wraps. A size code of 3 is compared against a 4-byte access. Idle cycles placed after reads show that the read result holds and that no bank is written.

// File: rtl/ubp_pkg.sv
package ubp_pkg;
  localparam int BYTE_W = 8;
  localparam int BANKS  = 4;
  localparam int SEL_W  = $clog2(BANKS);
  localparam int WORD_W = BANKS * BYTE_W;

  typedef enum logic [1:0] {
    SZ_ONE  = 2'd0,
    SZ_TWO  = 2'd1,
    SZ_FOUR = 2'd2,
    SZ_WIDE = 2'd3
  } sizeCode_e;

  typedef struct packed {
    logic [BANKS-1:0] bankBump;
    logic [BANKS-1:0] bankWrite;
    logic [BANKS-1:0] laneKeep;
    logic [SEL_W-1:0] rot;
    logic             capture;
  } strobe_t;
endpackage

// File: rtl/ubp_ctrl.sv
module ubp_ctrl
  import ubp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [SEL_W-1:0] reqOffset,
  input  logic [1:0]       reqSize,
  input  logic             reqWrite,
  output strobe_t          strobe
);
  logic [SEL_W:0] byteCount;

  always_comb begin
    case (sizeCode_e'(reqSize))
      SZ_ONE:  byteCount = (SEL_W+1)'(1);
      SZ_TWO:  byteCount = (SEL_W+1)'(2);
      default: byteCount = (SEL_W+1)'(BANKS);
    endcase
  end

  always_comb begin
    logic [SEL_W-1:0] rel;
    strobe = '0;
    strobe.rot = reqOffset;
    strobe.capture = reqValid && !reqWrite;
    for (int b = 0; b < BANKS; b++) begin
      rel = SEL_W'(b) - reqOffset;
      strobe.bankBump[b]  = SEL_W'(b) < reqOffset;
      strobe.bankWrite[b] = reqValid && reqWrite && ({1'b0, rel} < byteCount);
      strobe.laneKeep[b]  = (SEL_W+1)'(b) < byteCount;
    end
  end

  // R4: a one-byte write touches exactly one bank
  assert_byte_one_bank_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == 2'd0) |-> $onehot(strobe.bankWrite));

  // R4: a two-byte write touches exactly two banks
  assert_half_two_banks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == 2'd1) |-> $countones(strobe.bankWrite) == 2);

  // R4: a four-byte write touches every bank
  assert_word_all_banks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize[1]) |-> (&strobe.bankWrite));
endmodule

// File: rtl/ubp_dp.sv
module ubp_dp
  import ubp_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int BANK_AW = ADDR_W - SEL_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [WORD_W-1:0]        reqWdata,
  input  logic [WORD_W-1:0]        bankRdata,
  input  strobe_t                  strobe,
  output logic [BANKS*BANK_AW-1:0] bankAddr,
  output logic [WORD_W-1:0]        bankWdata,
  output logic [BANKS-1:0]         bankWe,
  output logic [WORD_W-1:0]        rdData,
  output logic                     rdValid
);
  logic [BANK_AW-1:0] baseWord;
  logic [WORD_W-1:0]  assembled;

  assign baseWord = reqAddr[ADDR_W-1:SEL_W];
  assign bankWe   = strobe.bankWrite;

  for (genvar b = 0; b < BANKS; b++) begin : gBankAddr
    assign bankAddr[b*BANK_AW +: BANK_AW] = baseWord + BANK_AW'(strobe.bankBump[b]);
  end

  // write crossbar: operand lane -> bank
  always_comb begin
    logic [SEL_W-1:0] lane;
    bankWdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      lane = SEL_W'(b) - strobe.rot;
      bankWdata[b*BYTE_W +: BYTE_W] = reqWdata[int'(lane)*BYTE_W +: BYTE_W];
    end
  end

  // read crossbar: bank -> operand lane, lanes beyond size cleared
  always_comb begin
    logic [SEL_W-1:0] src;
    assembled = '0;
    for (int i = 0; i < BANKS; i++) begin
      src = SEL_W'(i) + strobe.rot;
      assembled[i*BYTE_W +: BYTE_W] =
        strobe.laneKeep[i] ? bankRdata[int'(src)*BYTE_W +: BYTE_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= assembled;
    end
  end

  // R6: a read request yields a valid result next cycle
  assert_rd_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> rdValid);

  // R6: result register holds when no read is requested
  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(rdData));

  // R8: a read never writes a bank
  assert_no_write_on_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> (bankWe == '0));

  // R5: a single-byte read returns zero in upper lanes
  assert_narrow_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.laneKeep[1]) |=> (rdData[WORD_W-1:BYTE_W] == '0));
endmodule

// File: rtl/unaligned_bank_port.sv
module unaligned_bank_port
  import ubp_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int BANK_AW = ADDR_W - SEL_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [1:0]               reqSize,
  input  logic                     reqWrite,
  input  logic [WORD_W-1:0]        reqWdata,
  input  logic [WORD_W-1:0]        bankRdata,
  output logic [BANKS*BANK_AW-1:0] bankAddr,
  output logic [WORD_W-1:0]        bankWdata,
  output logic [BANKS-1:0]         bankWe,
  output logic [WORD_W-1:0]        rdData,
  output logic                     rdValid
);
  strobe_t strobe;

  ubp_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOffset (reqAddr[SEL_W-1:0]),
    .reqSize   (reqSize),
    .reqWrite  (reqWrite),
    .strobe    (strobe)
  );

  ubp_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .bankRdata (bankRdata),
    .strobe    (strobe),
    .bankAddr  (bankAddr),
    .bankWdata (bankWdata),
    .bankWe    (bankWe),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );
endmodule

// File: tb/unaligned_bank_port_test.sv
module unaligned_bank_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [31:0]  reqAddr = '0;
  logic [1:0]   reqSize = '0;
  logic         reqWrite = 1'b0;
  logic [31:0]  reqWdata = '0;
  logic [31:0]  bankRdata;
  logic [119:0] bankAddr;
  logic [31:0]  bankWdata;
  logic [3:0]   bankWe;
  logic [31:0]  rdData;
  logic         rdValid;

  int checks = 0;
  int failures = 0;
  logic [7:0] refMem [MEM_BYTES];
  logic [7:0] bankMem [4][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  unaligned_bank_port uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .bankRdata(bankRdata), .bankAddr(bankAddr), .bankWdata(bankWdata),
    .bankWe(bankWe), .rdData(rdData), .rdValid(rdValid)
  );

  // bank model: combinational read, write at clock edge
  always_comb begin
    for (int b = 0; b < 4; b++)
      bankRdata[b*8 +: 8] = bankMem[b][bankAddr[b*30 +: 4]];
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      for (int w = 0; w < 16; w++)
        if (!rstN) bankMem[b][w] <= 8'h00;
      if (rstN && bankWe[b]) bankMem[b][bankAddr[b*30 +: 4]] <= bankWdata[b*8 +: 8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic access(input bit wr, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input string tag);
    int n;
    int off;
    logic [3:0]  expWe;
    logic [31:0] expRead;
    logic [29:0] expBank;
    n = lenOf(sz);
    off = int'(addr[1:0]);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = sz; reqWdata = wd;
    #1;
    for (int b = 0; b < 4; b++) begin
      expBank = addr[31:2] + ((b < off) ? 30'd1 : 30'd0);
      chk({"R2 bank word address ", tag}, {2'b00, bankAddr[b*30 +: 30]}, {2'b00, expBank});
    end
    expWe = '0;
    expRead = '0;
    for (int i = 0; i < n; i++) begin
      if (wr) expWe[(off + i) % 4] = 1'b1;
      expRead[i*8 +: 8] = refMem[(int'(addr[5:0]) + i) % MEM_BYTES];
    end
    chk(wr ? {"R4 write enables ", tag} : {"R8 no enable on read ", tag},
        {28'd0, bankWe}, {28'd0, expWe});
    if (wr) begin
      for (int i = 0; i < n; i++) begin
        chk({"R3 write routing ", tag}, {24'd0, bankWdata[((off + i) % 4)*8 +: 8]},
            {24'd0, wd[i*8 +: 8]});
        refMem[(int'(addr[5:0]) + i) % MEM_BYTES] = wd[i*8 +: 8];
      end
    end
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    chk({"R6 valid after request ", tag}, {31'd0, rdValid}, {31'd0, !wr});
    if (!wr) chk({"R5 R7 read assembly ", tag}, rdData, expRead);
  endtask

  task automatic idleCheck();
    logic [31:0] held;
    held = rdData;
    @(negedge clk);
    chk("R6 valid low when idle", {31'd0, rdValid}, 32'd0);
    chk("R6 result holds when idle", rdData, held);
    chk("R8 no enable when idle", {28'd0, bankWe}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < MEM_BYTES; k++) refMem[k] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, rdValid}, 32'd0);
    chk("R1 reset data", rdData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release valid", {31'd0, rdValid}, 32'd0);
    chk("R1 after release data", rdData, 32'd0);

    // full sweep over addresses and sizes
    for (int a = 0; a < MEM_BYTES; a++) begin
      for (int s = 0; s < 3; s++) begin
        logic [31:0] wd;
        wd = 32'h9E3779B9 * (a * 3 + s + 1);
        access(1'b1, 32'(a), 2'(s), wd, "sweep write");
        access(1'b0, 32'(a), 2'(s), 32'd0, "sweep read");
        access(1'b0, 32'(a), 2'd2, 32'd0, "word readback");
        if ((a % 8) == 7) idleCheck();
      end
    end

    // size code 3 behaves as four bytes
    access(1'b1, 32'd5, 2'd3, 32'hC0FFEE42, "R4 size3 write");
    access(1'b0, 32'd5, 2'd3, 32'd0, "R5 size3 read");
    access(1'b0, 32'd5, 2'd2, 32'd0, "R7 size3 readback");

    // top of address space: increment wraps
    for (int o = 0; o < 4; o++) begin
      access(1'b0, 32'hFFFFFFFC + 32'(o), 2'd2, 32'd0, "R2 R7 top wrap");
      access(1'b0, 32'h2468ACE0 + 32'(o), 2'd1, 32'd0, "R2 high address");
    end
    access(1'b1, 32'hFFFFFFFE, 2'd2, 32'h5566AA77, "R7 wrap write");
    access(1'b0, 32'hFFFFFFFE, 2'd2, 32'd0, "R7 wrap read");
    idleCheck();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule